// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Skips

This block keeps the fetch address for a small microcontroller with 12-bit instruction words and a two-stage fetch/execute pipeline. In every cycle it looks at the word now in execute and at two side inputs from the execute unit. The first is a condition bit. The second is a strobe that says the instruction wrote the program counter as a data register. From these the block picks the next fetch address. The choices are the next sequential address, a 9-bit jump target, a subroutine entry, the address from a two-entry return stack, or the written data byte.

The block drops a taken branch, a return, a program-counter write or a satisfied skip by raising `flush`. The word fetched in that same cycle then occupies a dead execute slot. In the dead slot the block ignores that word, and the slot only advances the address. This gives every such instruction two cycles, and ordinary instructions one cycle. A return also hands its 8-bit literal to the working register through `w_load`/`w_load_data`.

The program counter is 9 bits wide. Only the absolute jump can set bit 8. A call or a register write always lands in the lower 256 words.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high, `fetch_pc` is 0x1FF. The first execute slot after reset is dead, and after it `fetch_pc` is 0x000.
- R2: An instruction that takes no branch and no skip reports `exec_cycles` = 1 and no `flush`. `fetch_pc` then advances by one, and 0x1FF wraps to 0x000.
- R3: An absolute jump (word bits [11:9] = 101) loads all 9 bits of `fetch_pc` from word bits [8:0]. It asserts `flush` and reports `exec_cycles` = 2.
- R4: A call (bits [11:8] = 1001) loads `fetch_pc` with {0, bits [7:0]}, so bit 8 is zero. It saves the current `fetch_pc` as the return address, asserts `flush` and reports 2 cycles.
- R5: A return (bits [11:8] = 1000) loads `fetch_pc` from the return stack. In the same cycle it asserts `w_load` with `w_load_data` = bits [7:0], asserts `flush` and reports 2 cycles.
- R6: A live cycle with `pc_file_we` high that is not a jump, call or return loads `fetch_pc` with {0, `pc_file_data`}. It asserts `flush` and reports 2 cycles.
- R7: The bit tests use bits [11:9] = 011. Bit 8 = 0 skips when `cond_in` is 0, and bit 8 = 1 skips when `cond_in` is 1. The count-and-test ops use bits [11:6] = 001011 or 001111 and skip when `cond_in` is 1. A skip asserts `flush`, reports 2 cycles and advances by one. No other opcode skips.
- R8: In a dead slot the word, `cond_in` and `pc_file_we` have no effect. The slot reports `exec_cycles` = 0, with no `flush` and no `w_load`, and `fetch_pc` advances by one.
- R9: The return stack holds two addresses. A third call drops the oldest one, and returns come back newest first.
- R10: A return with no saved address left goes to the address that the most recent return used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_word | input | 12 | Instruction word in the execute stage |
| cond_in | input | 1 | Tested bit value, or result-is-zero for count-and-test ops |
| pc_file_we | input | 1 | The executing instruction writes the program counter as a register |
| pc_file_data | input | 8 | Byte written to the program counter |
| fetch_pc | output | 9 | Address of the word being fetched |
| flush | output | 1 | Drop the word fetched this cycle; its slot executes as no-op |
| exec_cycles | output | 2 | Cycles charged this slot: 0 dead, 1 normal, 2 branch or skip |
| w_load | output | 1 | Write `w_load_data` into the working register |
| w_load_data | output | 8 | Literal carried by a return |

## Verification
A dead-slot flag stuck in the wrong state shows up at once. Either `exec_cycles` reports 0 in a live slot, or a word that should be squashed raises `flush` or `w_load` one cycle after a branch. A corrupted stack entry or fill count stays hidden until the return that uses it. It then shows as a wrong `fetch_pc` on the edge that follows that return, which may be many cycles after the bad push. For that reason the stack tests run nested calls, an overflow and returns from an empty stack. A wrong bit 8 on a call or register write shows at the next edge.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int IW            = 12;
    localparam int LIT_W         = 8;
    localparam int DEF_PC_W      = 9;
    localparam int DEF_STK_DEPTH = 2;

    typedef enum logic [2:0] {
        NXT_INC,
        NXT_JUMP,
        NXT_CALL,
        NXT_RET,
        NXT_FILE
    } nxt_sel_e;

    typedef struct packed {
        logic jump;
        logic call;
        logic ret;
        logic test;
        logic skip_when;
    } op_class_t;

    typedef struct packed {
        nxt_sel_e sel;
        logic     taken;
        logic     push;
        logic     pop;
        logic     wload;
    } step_plan_t;

    // Sort a word into the classes that affect program flow.
    function automatic op_class_t classify(input logic [IW-1:0] w);
        op_class_t c;
        c      = '0;
        c.jump = (w[11:9] == 3'b101);
        c.call = (w[11:8] == 4'b1001);
        c.ret  = (w[11:8] == 4'b1000);
        if (w[11:9] == 3'b011) begin
            c.test      = 1'b1;
            c.skip_when = w[8];
        end else if (w[11:6] == 6'b001011 || w[11:6] == 6'b001111) begin
            c.test      = 1'b1;
            c.skip_when = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/pc_decode.sv
module pc_decode
    import pcseq_pkg::*;
(
    input  logic [IW-1:0] word,
    input  logic          cond,
    input  logic          file_we,
    input  logic          live,
    output step_plan_t    plan
);

    op_class_t cls;
    assign cls = classify(word);

    always_comb begin
        plan.sel   = NXT_INC;
        plan.taken = 1'b0;
        plan.push  = 1'b0;
        plan.pop   = 1'b0;
        plan.wload = 1'b0;
        if (live) begin
            if (cls.jump) begin
                plan.sel   = NXT_JUMP;
                plan.taken = 1'b1;
            end else if (cls.call) begin
                plan.sel   = NXT_CALL;
                plan.taken = 1'b1;
                plan.push  = 1'b1;
            end else if (cls.ret) begin
                plan.sel   = NXT_RET;
                plan.taken = 1'b1;
                plan.pop   = 1'b1;
                plan.wload = 1'b1;
            end else if (file_we) begin
                plan.sel   = NXT_FILE;
                plan.taken = 1'b1;
            end else if (cls.test && (cond == cls.skip_when)) begin
                plan.taken = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int DEPTH = 2,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     ent [DEPTH];
    logic [CNT_W-1:0] fill;
    logic             shift_up;

    // With one or zero entries left, a pop keeps the head in place.
    assign shift_up = pop && !push && (fill > CNT_W'(1));
    assign top      = ent[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (push) begin
            ent[0] <= push_data;
            for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
        end else if (shift_up) begin
            for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (push) begin
            if (fill != FULL) fill <= fill + CNT_W'(1);
        end else if (pop) begin
            if (fill != '0) fill <= fill - CNT_W'(1);
        end
    end

endmodule

// File: rtl/pc_next.sv
module pc_next
    import pcseq_pkg::*;
#(
    parameter int PC_W = 9
) (
    input  nxt_sel_e         sel,
    input  logic [PC_W-1:0]  pc,
    input  logic [IW-1:0]    word,
    input  logic [LIT_W-1:0] file_data,
    input  logic [PC_W-1:0]  stack_top,
    output logic [PC_W-1:0]  next
);

    localparam int HI_W = PC_W - LIT_W;

    always_comb begin
        unique case (sel)
            NXT_JUMP: next = word[PC_W-1:0];
            NXT_CALL: next = {{HI_W{1'b0}}, word[LIT_W-1:0]};
            NXT_RET:  next = stack_top;
            NXT_FILE: next = {{HI_W{1'b0}}, file_data};
            default:  next = pc + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W      = DEF_PC_W,
    parameter int STK_DEPTH = DEF_STK_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    exec_word,
    input  logic             cond_in,
    input  logic             pc_file_we,
    input  logic [LIT_W-1:0] pc_file_data,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             flush,
    output logic [1:0]       exec_cycles,
    output logic             w_load,
    output logic [LIT_W-1:0] w_load_data
);

    localparam logic [PC_W-1:0] PC_RESET = '1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] stk_top;
    logic            dead_q;
    step_plan_t      plan;

    pc_decode u_decode (
        .word    (exec_word),
        .cond    (cond_in),
        .file_we (pc_file_we),
        .live    (!dead_q),
        .plan    (plan)
    );

    pc_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (plan.push),
        .pop       (plan.pop),
        .push_data (pc_q),
        .top       (stk_top)
    );

    pc_next #(.PC_W(PC_W)) u_next (
        .sel       (plan.sel),
        .pc        (pc_q),
        .word      (exec_word),
        .file_data (pc_file_data),
        .stack_top (stk_top),
        .next      (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= PC_RESET;
            dead_q <= 1'b1;
        end else begin
            pc_q   <= pc_d;
            dead_q <= plan.taken;
        end
    end

    assign fetch_pc    = pc_q;
    assign flush       = plan.taken;
    assign exec_cycles = dead_q ? 2'd0 : (plan.taken ? 2'd2 : 2'd1);
    assign w_load      = plan.wload;
    assign w_load_data = exec_word[LIT_W-1:0];

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int PC_W = 9
) (
    input logic            clk,
    input logic            rst,
    input logic [11:0]     exec_word,
    input logic            pc_file_we,
    input logic [7:0]      pc_file_data,
    input logic [PC_W-1:0] fetch_pc,
    input logic            flush,
    input logic [1:0]      exec_cycles,
    input logic            w_load,
    input logic [7:0]      w_load_data
);

    logic slot_dead;
    logic is_jump, is_call, is_ret;

    always_ff @(posedge clk) begin
        if (rst) slot_dead <= 1'b1;
        else     slot_dead <= flush;
    end

    assign is_jump = (exec_word[11:9] == 3'b101);
    assign is_call = (exec_word[11:8] == 4'b1001);
    assign is_ret  = (exec_word[11:8] == 4'b1000);

    AST_DEAD_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        slot_dead |-> (!flush && exec_cycles == 2'd0 && !w_load)); // R8

    AST_NO_FLUSH_PAIR: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush); // R8

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (exec_cycles == 2'd1) |=> (fetch_pc == PC_W'($past(fetch_pc) + 1'b1))); // R2

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!slot_dead && is_jump) |=> (fetch_pc == PC_W'($past(exec_word[8:0])))); // R3

    AST_CALL_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        (!slot_dead && is_call) |=> (fetch_pc == PC_W'($past(exec_word[7:0])))); // R4

    AST_RET_LOADS_W: assert property (@(posedge clk) disable iff (rst)
        (!slot_dead && is_ret) |-> (w_load && flush && w_load_data == exec_word[7:0])); // R5

    AST_FILE_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        (!slot_dead && pc_file_we && !is_jump && !is_call && !is_ret)
        |=> (fetch_pc == PC_W'($past(pc_file_data)))); // R6

    AST_TWO_CYCLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (exec_cycles == 2'd2) == flush); // R7

endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .exec_word    (exec_word),
    .pc_file_we   (pc_file_we),
    .pc_file_data (pc_file_data),
    .fetch_pc     (fetch_pc),
    .flush        (flush),
    .exec_cycles  (exec_cycles),
    .w_load       (w_load),
    .w_load_data  (w_load_data)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] exec_word = '0;
    logic        cond_in = 1'b0;
    logic        pc_file_we = 1'b0;
    logic [7:0]  pc_file_data = '0;
    logic [8:0]  fetch_pc;
    logic        flush;
    logic [1:0]  exec_cycles;
    logic        w_load;
    logic [7:0]  w_load_data;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [8:0] epc;
    bit         done = 0;

    localparam logic [11:0] NOP = 12'h000;

    always #2 clk = ~clk;

    pc_sequencer u0 (
        .clk          (clk),
        .rst          (rst),
        .exec_word    (exec_word),
        .cond_in      (cond_in),
        .pc_file_we   (pc_file_we),
        .pc_file_data (pc_file_data),
        .fetch_pc     (fetch_pc),
        .flush        (flush),
        .exec_cycles  (exec_cycles),
        .w_load       (w_load),
        .w_load_data  (w_load_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic live(input logic [11:0] w, input logic c, input logic we,
                        input logic [7:0] d, input logic e_fl, input logic [1:0] e_cy,
                        input logic e_wl, input logic [7:0] e_wd,
                        input logic [8:0] e_pc, input string req);
        exec_word = w; cond_in = c; pc_file_we = we; pc_file_data = d;
        #1;
        chk(req, "flush", flush, e_fl);
        chk(req, "exec_cycles", exec_cycles, e_cy);
        chk(req, "w_load", w_load, e_wl);
        if (e_wl) chk(req, "w_load_data", w_load_data, e_wd);
        @(posedge clk); #1;
        chk(req, "fetch_pc", fetch_pc, e_pc);
        epc = e_pc;
        @(negedge clk);
    endtask

    task automatic dead(input logic [11:0] w, input logic c, input logic we,
                        input logic [7:0] d, input string req);
        exec_word = w; cond_in = c; pc_file_we = we; pc_file_data = d;
        #1;
        chk(req, "dead flush", flush, 1'b0);
        chk(req, "dead exec_cycles", exec_cycles, 2'd0);
        chk(req, "dead w_load", w_load, 1'b0);
        @(posedge clk); #1;
        chk(req, "dead fetch_pc", fetch_pc, 9'(epc + 9'd1));
        epc = 9'(epc + 9'd1);
        @(negedge clk);
    endtask

    task automatic seq(input logic [11:0] w, input logic c, input string req);
        live(w, c, 1'b0, 8'h00, 1'b0, 2'd1, 1'b0, 8'h00, 9'(epc + 9'd1), req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset fetch_pc", fetch_pc, 9'h1FF);
        chk("R1", "reset flush", flush, 1'b0);
        chk("R1", "reset exec_cycles", exec_cycles, 2'd0);
        rst = 1'b0;
        epc = 9'h1FF;
        // R1: the first slot is dead even when it holds a jump and a write
        dead(12'hA55, 1'b1, 1'b1, 8'h33, "R1");
        chk("R1", "first live address", epc, 9'h000);
        seq(NOP, 1'b0, "R2");
    endtask

    task automatic t_goto_wrap;
        live(12'hBFE, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h1FE, "R3");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R8");
        seq(NOP, 1'b1, "R2");
        chk("R2", "wrap to zero", fetch_pc, 9'h000);
    endtask

    task automatic t_call_ret;
        logic [8:0] ret_a;
        live(12'hB50, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h150, "R3");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R8");
        ret_a = epc;
        live(12'h980, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h080, "R4");
        // R8: return word plus a register write in a dead slot must not pop
        dead(12'h899, 1'b1, 1'b1, 8'h12, "R8");
        live(12'h83C, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 8'h3C, ret_a, "R5");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R8");
    endtask

    task automatic t_stack;
        logic [8:0] r2, r3;
        live(12'h910, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h010, "R4");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R9");
        r2 = epc;
        live(12'h920, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h020, "R4");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R9");
        r3 = epc;
        live(12'h930, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h030, "R9");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R9");
        live(12'h801, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 8'h01, r3, "R9");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R9");
        live(12'h802, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 8'h02, r2, "R9");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R9");
        live(12'h803, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 8'h03, r2, "R10");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R10");
        live(12'h804, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 8'h04, r2, "R10");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R10");
    endtask

    task automatic t_skip;
        logic [11:0] ops [4];
        ops[0] = 12'h6A5; // bit test, skip when clear
        ops[1] = 12'h7A5; // bit test, skip when set
        ops[2] = 12'h2E6; // decrement-and-test
        ops[3] = 12'h3E6; // increment-and-test
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 2; c++) begin
                bit sk;
                sk = (k == 0) ? (c == 0) : (c == 1);
                if (sk) begin
                    live(ops[k], 1'(c), 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00,
                         9'(epc + 9'd1), "R7");
                    dead(12'hA00, 1'b0, 1'b0, 8'h00, "R7");
                end else begin
                    seq(ops[k], 1'(c), "R7");
                end
            end
        end
        seq(12'h0E6, 1'b1, "R7");
    endtask

    task automatic t_file;
        live(12'hBA0, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 8'h00, 9'h1A0, "R3");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R8");
        live(12'h022, 1'b0, 1'b1, 8'h77, 1'b1, 2'd2, 1'b0, 8'h00, 9'h077, "R6");
        dead(NOP, 1'b0, 1'b1, 8'hEE, "R8");
        live(12'h022, 1'b0, 1'b1, 8'hFF, 1'b1, 2'd2, 1'b0, 8'h00, 9'h0FF, "R6");
        dead(NOP, 1'b0, 1'b0, 8'h00, "R6");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        t_reset();
        t_goto_wrap();
        t_call_ret();
        t_stack();
        t_skip();
        t_file();
        done = 1;
        summary();
    end

endmodule